// File: doc/BRIEF.md
# Configurable UART serial framer

This block is the serial engine of a byte-wide UART. It holds a transmit path that turns bytes into asynchronous serial frames and a receive path that turns frames back into bytes. A shared tick generator divides the core clock by a 16-bit divisor to produce a 16x oversampling tick. The divisor holds the tick period minus one, so one serial bit lasts 16 × (divisor + 1) clocks. The slowest rate is clk/(16×65536) and the fastest is clk/256 when the tick is used as intended (divisor ≥ 15). Smaller divisor values still work and give faster rates.

A format byte is applied at run time. It selects 7 or 8 data bits, one or two stop bits, and no parity, even parity or odd parity. Bytes to transmit enter through a ready/valid port into a one-byte holding stage that feeds the shift register. An idle flag reports when neither the holding stage nor the shifter has anything left. Each received byte leaves on a valid/ready port and carries its own parity, framing and overrun flags.

Top module: `uart_framer`

## Requirements
- R1: After reset, the serial output is high, the transmit input is ready, the transmitter reports idle and no received byte is valid.
- R2: Each serial bit, the start bit included, lasts exactly 16 × (divisor + 1) clock cycles on the transmit line.
- R3: A transmitted frame is one low start bit, then the data bits least significant first. There are 8 data bits when format bit 0 is 1 and 7 (bits 6..0) when it is 0. The line idles high.
- R4: When format bit 2 is set, one parity bit follows the data bits. With format bit 4 clear, the parity bit makes the number of ones over data plus parity even. With format bit 4 set, it makes that number odd.
- R5: The frame ends with two high stop bits when format bit 1 is set and one when it is clear. The transmitter is not idle until the last stop bit is complete.
- R6: The holding stage takes one byte while the shifter is busy, and ready drops the cycle after an accepted byte. The idle flag is high only when both the holding stage and the shifter are empty.
- R7: A received frame in the selected format delivers its data on rx_data with rx_valid held until rx_ready. In 7-bit mode, bit 7 of rx_data is 0.
- R8: rx_perr is set on a delivered byte when parity is enabled and the received parity bit disagrees with the selected sense. Otherwise it is clear.
- R9: rx_ferr is set when the first stop bit samples low, and the byte is still delivered.
- R10: rx_oerr is set on a delivered byte when the previous byte was still valid and not being accepted at delivery. The new byte replaces the old one.
- R11: A low pulse on the receive line that has ended by the middle of the start bit (tick 8 after the falling edge) produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Oversampling tick period minus one, in clocks |
| fmt_cfg | input | 8 | Format byte: bit0 8-bit data, bit1 two stop bits, bit2 parity on, bit4 odd parity |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Holding stage can take a byte |
| tx_idle | output | 1 | Nothing left to shift out |
| tx_line | output | 1 | Serial output |
| rx_line | input | 1 | Serial input (asynchronous) |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data and flags are valid |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_perr | output | 1 | Parity error on this byte |
| rx_ferr | output | 1 | Framing error on this byte |
| rx_oerr | output | 1 | Previous byte was lost |

## Verification
The bench measures the start-bit length at several divisors, divisor 0 included. A generator that counts one tick too many or too few would stretch or shrink every bit by a full tick period. It compares complete frames in 7- and 8-bit, even, odd and no-parity formats, which exposes a parity sense that is reversed or data that is sent in the wrong order. It checks the idle flag at the centre of the second stop bit, which catches a transmitter that drops the extra stop bit. On the receive side it drives bad parity, a low stop bit, two unconsumed bytes and a short glitch. A wrong design would, in turn, miss a flag, drop the byte with the bad stop, keep the stale byte, or invent a byte from noise.

// File: rtl/uart_framer_pkg.sv
package uart_framer_pkg;

  localparam int FRAME_MAX = 12;

  typedef struct packed {
    logic odd;
    logic par_en;
    logic two_stop;
    logic len8;
  } line_fmt_t;

  function automatic line_fmt_t decode_fmt(input logic [7:0] c);
    line_fmt_t f;
    f.len8     = c[0];
    f.two_stop = c[1];
    f.par_en   = c[2];
    f.odd      = c[4];
    return f;
  endfunction

  function automatic logic [3:0] data_len(input line_fmt_t f);
    return f.len8 ? 4'd8 : 4'd7;
  endfunction

  function automatic logic [7:0] mask_data(input logic [7:0] d, input line_fmt_t f);
    return f.len8 ? d : {1'b0, d[6:0]};
  endfunction

  // even: total ones even, odd: total ones odd
  function automatic logic calc_parity(input logic [7:0] d, input line_fmt_t f);
    return (^mask_data(d, f)) ^ f.odd;
  endfunction

  function automatic logic [3:0] frame_len(input line_fmt_t f);
    return 4'd1 + data_len(f) + {3'd0, f.par_en} + (f.two_stop ? 4'd2 : 4'd1);
  endfunction

  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [7:0] d, input line_fmt_t f);
    logic [FRAME_MAX-1:0] fr;
    int n;
    n = int'(data_len(f));
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < n) fr[i+1] = d[i];
    if (f.par_en) fr[n+1] = calc_parity(d, f);
    return fr;
  endfunction

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= divisor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && divisor != '0 |=> !tick || divisor == '0);
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_framer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  line_fmt_t fmt,
  input  logic [7:0] tx_data,
  input  logic      tx_valid,
  output logic      tx_ready,
  output logic      tx_idle,
  output logic      tx_line
);
  localparam int TC_W = 4;

  logic                 hold_v;
  logic [7:0]           hold_d;
  logic                 busy;
  logic [FRAME_MAX-1:0] shreg;
  logic [3:0]           bit_no;
  logic [TC_W-1:0]      tcnt;
  logic                 load;
  logic                 bit_end;
  logic [3:0]           flen;

  assign flen     = frame_len(fmt);
  assign load     = !busy && hold_v && tick;
  assign bit_end  = busy && tick && (tcnt == '1);
  assign tx_ready = !hold_v;
  assign tx_idle  = !busy && !hold_v;
  assign tx_line  = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      busy   <= 1'b0;
      shreg  <= '1;
      bit_no <= '0;
      tcnt   <= '0;
    end else begin
      if (tx_valid && tx_ready) begin
        hold_v <= 1'b1;
        hold_d <= tx_data;
      end else if (load) begin
        hold_v <= 1'b0;
      end
      if (load) begin
        busy   <= 1'b1;
        shreg  <= build_frame(hold_d, fmt);
        bit_no <= '0;
        tcnt   <= '0;
      end else if (busy && tick) begin
        tcnt <= tcnt + 1'b1;
        if (bit_end) begin
          shreg  <= {1'b1, shreg[FRAME_MAX-1:1]};
          bit_no <= bit_no + 1'b1;
          if (bit_no == flen - 4'd1) busy <= 1'b0;
        end
      end
    end
  end

  a_r6_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);
  a_r6_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> tx_line);
  a_r3_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tx_line));
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_framer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  line_fmt_t  fmt,
  input  logic       rx_line,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       rx_perr,
  output logic       rx_ferr,
  output logic       rx_oerr
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

  rx_state_t  st;
  logic       s1, line, line_d;
  logic [3:0] tcnt;
  logic [3:0] idx;
  logic [9:0] recv;
  logic [3:0] stop_idx;
  logic       sample_now;
  logic       byte_done;
  logic [7:0] got_data;
  logic       got_par;

  assign stop_idx   = data_len(fmt) + {3'd0, fmt.par_en};
  assign sample_now = (st == RX_BITS) && tick && (tcnt == 4'd15);
  assign byte_done  = sample_now && (idx == stop_idx);
  assign got_data   = mask_data(recv[7:0], fmt);
  assign got_par    = fmt.len8 ? recv[8] : recv[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; line <= 1'b1; line_d <= 1'b1;
      st <= RX_IDLE; tcnt <= '0; idx <= '0; recv <= '0;
      rx_valid <= 1'b0; rx_data <= '0;
      rx_perr <= 1'b0; rx_ferr <= 1'b0; rx_oerr <= 1'b0;
    end else begin
      s1     <= rx_line;
      line   <= s1;
      line_d <= line;
      case (st)
        RX_IDLE:
          if (line_d && !line) begin
            st   <= RX_START;
            tcnt <= '0;
          end
        RX_START:
          if (tick) begin
            if (tcnt == 4'd7) begin
              if (!line) begin
                st   <= RX_BITS;
                tcnt <= '0;
                idx  <= '0;
              end else begin
                st <= RX_IDLE;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        default:
          if (tick) begin
            tcnt <= tcnt + 1'b1;
            if (sample_now) begin
              recv[idx] <= line;
              idx       <= idx + 1'b1;
              if (byte_done) st <= RX_IDLE;
            end
          end
      endcase
      if (byte_done) begin
        rx_valid <= 1'b1;
        rx_data  <= got_data;
        rx_perr  <= fmt.par_en && (got_par != calc_parity(got_data, fmt));
        rx_ferr  <= !line;
        rx_oerr  <= rx_valid && !rx_ready;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  a_r7_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);
  a_r10_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && rx_valid && !rx_ready |=> rx_oerr && rx_valid);
  a_r9_low_stop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !line |=> rx_ferr && rx_valid);
endmodule

// File: rtl/uart_framer.sv
module uart_framer
  import uart_framer_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [7:0]       fmt_cfg,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_idle,
  output logic             tx_line,
  input  logic             rx_line,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_oerr
);
  logic      tick;
  line_fmt_t fmt;
  logic      cfg_unused_bits;

  assign fmt             = decode_fmt(fmt_cfg);
  assign cfg_unused_bits = ^{fmt_cfg[7:5], fmt_cfg[3]};

  uart_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
  );

  uart_tx_engine u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_idle(tx_idle), .tx_line(tx_line)
  );

  uart_rx_engine u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt), .rx_line(rx_line),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_oerr(rx_oerr)
  );
endmodule

// File: tb/uart_framer_bench.sv
module uart_framer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic [7:0]  fmt_cfg = 8'h01;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_idle, tx_line;
  logic        rx_line = 1'b1;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_perr, rx_ferr, rx_oerr;
  logic        rx_ready = 1'b0;

  int checks = 0;
  int bad = 0;
  int per = 2;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_framer u_uart_framer (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .fmt_cfg(fmt_cfg),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_idle(tx_idle), .tx_line(tx_line), .rx_line(rx_line),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_oerr(rx_oerr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_div(input int d);
    @(negedge clk);
    divisor = 16'(d);
    per = d + 1;
  endtask

  // expected frame bits, LSB first, computed from the format rules
  task automatic exp_frame(input logic [7:0] d, input logic [7:0] c,
                           output logic [15:0] bits, output int n);
    int len, ones;
    len = c[0] ? 8 : 7;
    bits = '1; n = 0; ones = 0;
    bits[n++] = 1'b0;
    for (int i = 0; i < len; i++) begin
      bits[n++] = d[i];
      ones += int'(d[i]);
    end
    if (c[2]) bits[n++] = c[4] ? ((ones % 2) == 0) : ((ones % 2) == 1);
    bits[n++] = 1'b1;
    if (c[1]) bits[n++] = 1'b1;
  endtask

  task automatic wait_fall(output bit seen);
    seen = 0;
    for (int t = 0; t < 64 * per && !seen; t++) begin
      @(negedge clk);
      if (!tx_line) seen = 1;
    end
  endtask

  task automatic test_reset;
    check(tx_line == 1'b1, "R1 line", int'(tx_line), 1);
    check(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);
    check(tx_idle == 1'b1, "R1 idle", int'(tx_idle), 1);
    check(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
  endtask

  task automatic tx_frame(input logic [7:0] d, input logic [7:0] c, input string req);
    logic [15:0] exp, got;
    int n;
    bit seen;
    exp_frame(d, c, exp, n);
    @(negedge clk);
    fmt_cfg = c; tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    wait_fall(seen);
    check(seen, {req, " start seen"}, int'(seen), 1);
    got = '1;
    repeat (8 * per) @(negedge clk);
    got[0] = tx_line;
    check(!tx_idle, "R6 busy mid frame", int'(tx_idle), 0);
    for (int i = 1; i < n; i++) begin
      repeat (16 * per) @(negedge clk);
      got[i] = tx_line;
    end
    check(!tx_idle, "R5 busy in last stop", int'(tx_idle), 0);
    check(got == exp, req, int'(got), int'(exp));
    repeat (8 * per + 2) @(negedge clk);
    check(tx_idle, "R6 idle after frame", int'(tx_idle), 1);
  endtask

  task automatic bit_time(input int d);
    int low;
    bit seen;
    set_div(d);
    @(negedge clk);
    fmt_cfg = 8'h01; tx_data = 8'h01; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    wait_fall(seen);
    low = 1;
    while (!tx_line && low < 100000) begin
      @(negedge clk);
      if (!tx_line) low++;
    end
    check(low == 16 * per, "R2 start bit length", low, 16 * per);
    while (!tx_idle) @(negedge clk);
  endtask

  task automatic tx_back_to_back;
    @(negedge clk);
    fmt_cfg = 8'h01; tx_data = 8'h11; tx_valid = 1'b1;
    @(negedge clk);
    tx_data = 8'h22;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    check(!tx_ready, "R6 holding full", int'(tx_ready), 0);
    check(!tx_idle, "R6 not idle with byte held", int'(tx_idle), 0);
    while (!tx_idle) @(negedge clk);
    check(tx_ready && tx_line, "R6 drained", int'(tx_ready), 1);
  endtask

  task automatic rx_drive(input logic [7:0] d, input logic [7:0] c,
                          input bit bad_par, input bit bad_stop);
    logic [15:0] bits;
    int n, len;
    exp_frame(d, c, bits, n);
    len = c[0] ? 8 : 7;
    if (bad_par && c[2]) bits[len+1] = ~bits[len+1];
    if (bad_stop) bits[len + 1 + int'(c[2])] = 1'b0;
    @(negedge clk);
    fmt_cfg = c;
    for (int i = 0; i < n; i++) begin
      rx_line = bits[i];
      repeat (16 * per) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_expect(input logic [7:0] d, input bit pe, input bit fe,
                           input bit oe, input string req);
    check(rx_valid, {req, " valid"}, int'(rx_valid), 1);
    check(rx_data == d, {req, " data"}, int'(rx_data), int'(d));
    check(rx_perr == pe, "R8 parity flag", int'(rx_perr), int'(pe));
    check(rx_ferr == fe, "R9 framing flag", int'(rx_ferr), int'(fe));
    check(rx_oerr == oe, "R10 overrun flag", int'(rx_oerr), int'(oe));
  endtask

  task automatic rx_take;
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check(!rx_valid, "R7 valid drops on accept", int'(rx_valid), 0);
  endtask

  task automatic rx_glitch;
    @(negedge clk);
    rx_line = 1'b0;
    repeat (4 * per) @(negedge clk);
    rx_line = 1'b1;
    repeat (32 * per) @(negedge clk);
    check(!rx_valid, "R11 glitch rejected", int'(rx_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    set_div(1);
    tx_frame(8'hA5, 8'h01, "R3 8N1 frame");
    tx_frame(8'h3C, 8'h05, "R4 8E1 frame");
    tx_frame(8'h3C, 8'h15, "R4 8O1 frame");
    tx_frame(8'hDA, 8'h06, "R5 7E2 frame");
    tx_frame(8'h81, 8'h00, "R3 7N1 frame");
    bit_time(3);
    bit_time(0);
    bit_time(2);
    set_div(1);
    tx_back_to_back();
    rx_drive(8'h96, 8'h01, 0, 0); rx_expect(8'h96, 0, 0, 0, "R7 8N1"); rx_take();
    rx_drive(8'hC3, 8'h15, 0, 0); rx_expect(8'hC3, 0, 0, 0, "R7 8O1"); rx_take();
    rx_drive(8'hFF, 8'h06, 0, 0); rx_expect(8'h7F, 0, 0, 0, "R7 7E2"); rx_take();
    rx_drive(8'h5A, 8'h05, 1, 0); rx_expect(8'h5A, 1, 0, 0, "R8 bad parity"); rx_take();
    rx_drive(8'h24, 8'h01, 0, 1); rx_expect(8'h24, 0, 1, 0, "R9 low stop"); rx_take();
    rx_drive(8'h11, 8'h01, 0, 0);
    rx_drive(8'h22, 8'h01, 0, 0); rx_expect(8'h22, 0, 0, 1, "R10 overrun"); rx_take();
    rx_drive(8'h33, 8'h01, 0, 0); rx_expect(8'h33, 0, 0, 0, "R10 clear after take"); rx_take();
    rx_glitch();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule